// File: doc/BRIEF.md
# SSI Position Word Serializer

This block sends a position sample out over a synchronous serial link that an external master clocks. It runs on a local system clock. The incoming master clock is synchronized to that clock, and its edges are detected there. The first falling master edge of a frame freezes a copy of the position word, the two error flags and the frame configuration. Each later rising master edge drives the next bit of the frame onto the data line.

A 2-bit format code sets two things: whether three status bits follow the position data, and whether the frame wraps around and resends the frozen word. A resolution select chooses between the full word and a reduced 10-bit word. The frame ends when the master clock stays high for a programmable number of system clocks. The line then rests high until the next frame starts.

Top module: `ssi_pos_ser`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sdo` is 1.
- R2: The first falling edge of `mclk` outside a frame starts a frame. At that edge the block captures `pos_in`, `err_hi`, `err_lo`, `fmt` and `res_full`. Changes to these inputs later in the frame have no effect on the bits sent.
- R3: The falling edge that starts the frame leaves `sdo` at 1. The n-th rising edge of `mclk` in the frame drives bit n-1 of the frame sequence onto `sdo`. The value holds until the next rising edge.
- R4: Position data is sent in plain binary, most significant bit first. With `res_full`=1 the bits sent are pos[12] down to pos[0] (13 bits). With `res_full`=0 they are pos[9] down to pos[0] (10 bits).
- R5: When `fmt[0]`=1 (codes 1 and 3), the data is followed by the captured `err_hi`, then `err_lo`, then a 0 bit. These three bits are the trailing bits. When `fmt[0]`=0, no trailing bits are sent.
- R6: When `fmt[1]`=0 (codes 0 and 1), every bit after the data and any trailing bits is 0.
- R7: When `fmt[1]`=1 (codes 2 and 3), one 0 stop bit follows the data and any trailing bits. The same captured data and trailing bits then repeat from the most significant bit, with one stop bit between repeats, for as long as rising edges arrive.
- R8: If the synchronized `mclk` stays high for `tmo_limit` consecutive system clocks during a frame, the frame ends and `sdo` returns to 1. The next falling edge starts a new frame with a new capture, per R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master clock from the link, asynchronous to `clk`; idles high |
| pos_in | input | 13 | Position sample |
| err_hi | input | 1 | First error flag (sent first when trailing bits are enabled) |
| err_lo | input | 1 | Second error flag |
| fmt | input | 2 | Frame format: bit 0 enables the trailing bits, bit 1 enables ring mode |
| res_full | input | 1 | 1 = send the full 13-bit word, 0 = send 10 bits |
| tmo_limit | input | 16 | End-of-frame timeout, in system clocks of continuous high `mclk` |
| sdo | output | 1 | Serial data line, registered |

## Verification
The case hardest to reach from the ports is an input change during a frame. The frozen capture must win over the live inputs. Outside a frame, a new value looks the same as a changed one. The bench therefore starts frames with one set of inputs and inverts the position word, both flags, the format code and the resolution after a few bits. It then checks every later bit against the original set. It also ends a frame by timeout after only two bits and starts a new frame at once. This shows that the bit counter restarts at the most significant bit and that a fresh capture is taken.

// File: rtl/ssi_ser_pkg.sv
package ssi_ser_pkg;

  // Frame format codes: bit 0 adds status bits, bit 1 enables wrap-around.
  typedef enum logic [1:0] {
    FMT_PLAIN    = 2'd0,
    FMT_STATUS   = 2'd1,
    FMT_RING     = 2'd2,
    FMT_RING_STS = 2'd3
  } ssi_fmt_e;

  localparam int SSI_TRAIL_BITS = 3;

  function automatic logic fmt_has_status(input logic [1:0] code);
    return code[0];
  endfunction

  function automatic logic fmt_is_ring(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/ssi_mclk_sync.sv
module ssi_mclk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_async,
  output logic mclk_s,
  output logic mclk_rise,
  output logic mclk_fall
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  // The link clock idles high, so every stage resets to 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], mclk_async};
      prev_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign mclk_s    = chain_q[SYNC_STAGES-1];
  assign mclk_rise = mclk_s & ~prev_q;
  assign mclk_fall = ~mclk_s & prev_q;

endmodule

// File: rtl/ssi_frame_ctrl.sv
module ssi_frame_ctrl #(
  parameter int POS_W = 13,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_s,
  input  logic             mclk_fall,
  input  logic [POS_W-1:0] pos_in,
  input  logic             err_hi,
  input  logic             err_lo,
  input  logic [1:0]       fmt,
  input  logic             res_full,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             start,
  output logic             tmo_hit,
  output logic [POS_W-1:0] snap_pos,
  output logic             snap_hi,
  output logic             snap_lo,
  output logic [1:0]       snap_fmt,
  output logic             snap_full
);

  logic [TMO_W-1:0] hi_cnt_q;
  logic [TMO_W:0]   hi_cnt_nxt;

  assign start      = mclk_fall & ~busy;
  assign hi_cnt_nxt = {1'b0, hi_cnt_q} + 1'b1;
  assign tmo_hit    = busy & mclk_s & (hi_cnt_nxt >= {1'b0, tmo_limit});

  // Count consecutive high cycles of the link clock within a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q <= '0;
    end else if (!busy || !mclk_s || tmo_hit) begin
      hi_cnt_q <= '0;
    end else begin
      hi_cnt_q <= hi_cnt_nxt[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
    end else if (tmo_hit) begin
      busy <= 1'b0;
    end
  end

  // Snapshot of data and configuration, frozen for the whole frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_pos  <= '0;
      snap_hi   <= 1'b0;
      snap_lo   <= 1'b0;
      snap_fmt  <= 2'b00;
      snap_full <= 1'b1;
    end else if (start) begin
      snap_pos  <= pos_in;
      snap_hi   <= err_hi;
      snap_lo   <= err_lo;
      snap_fmt  <= fmt;
      snap_full <= res_full;
    end
  end

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && !tmo_hit |=> $stable(snap_pos) && $stable(snap_fmt) && $stable(snap_full)); // R2

  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |=> !busy); // R8

endmodule

// File: rtl/ssi_bit_seq.sv
module ssi_bit_seq
  import ssi_ser_pkg::*;
#(
  parameter int POS_W  = 13,
  parameter int LO_RES = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             start,
  input  logic             tmo_hit,
  input  logic             mclk_rise,
  input  logic [POS_W-1:0] snap_pos,
  input  logic             snap_hi,
  input  logic             snap_lo,
  input  logic [1:0]       snap_fmt,
  input  logic             snap_full,
  output logic             sdo
);

  localparam int MAX_PAY = POS_W + SSI_TRAIL_BITS;
  localparam int IDX_W   = $clog2(MAX_PAY + 2);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] data_len;
  logic [IDX_W-1:0] pay_len;
  logic [IDX_W-1:0] idx_nxt;
  logic [POS_W-1:0] shifted;
  logic             cur_bit;
  logic             sts_en;
  logic             ring_en;

  assign sts_en  = fmt_has_status(snap_fmt);
  assign ring_en = fmt_is_ring(snap_fmt);

  // The resolution picks how many data bits are sent.
  generate
    if (LO_RES < POS_W) begin : g_two_res
      assign data_len = snap_full ? IDX_W'(POS_W) : IDX_W'(LO_RES);
    end else begin : g_one_res
      assign data_len = IDX_W'(POS_W);
    end
  endgenerate

  assign pay_len = data_len + (sts_en ? IDX_W'(SSI_TRAIL_BITS) : IDX_W'(0));
  assign shifted = snap_pos >> (data_len - idx_q - 1'b1);

  always_comb begin
    cur_bit = 1'b0;
    if (idx_q < data_len) begin
      cur_bit = shifted[0];
    end else if (sts_en && idx_q == data_len) begin
      cur_bit = snap_hi;
    end else if (sts_en && idx_q == data_len + 1'b1) begin
      cur_bit = snap_lo;
    end
  end

  // Index pay_len is the stop position: held when the frame does not
  // wrap, left after one bit when it does.
  always_comb begin
    if (idx_q < pay_len) begin
      idx_nxt = idx_q + 1'b1;
    end else if (ring_en) begin
      idx_nxt = '0;
    end else begin
      idx_nxt = pay_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (start) begin
      idx_q <= '0;
    end else if (busy && mclk_rise) begin
      idx_q <= idx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo <= 1'b1;
    end else if (tmo_hit) begin
      sdo <= 1'b1;
    end else if (busy && mclk_rise) begin
      sdo <= cur_bit;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sdo); // R1

  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    start |=> sdo); // R3

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= pay_len || !busy); // R7

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    busy && mclk_rise && !tmo_hit && idx_q >= pay_len |=> !sdo); // R6

endmodule

// File: rtl/ssi_pos_ser.sv
module ssi_pos_ser #(
  parameter int POS_W       = 13,
  parameter int LO_RES      = 10,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk,
  input  logic [POS_W-1:0] pos_in,
  input  logic             err_hi,
  input  logic             err_lo,
  input  logic [1:0]       fmt,
  input  logic             res_full,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             sdo
);

  logic             mclk_s;
  logic             mclk_rise;
  logic             mclk_fall;
  logic             busy;
  logic             start;
  logic             tmo_hit;
  logic [POS_W-1:0] snap_pos;
  logic             snap_hi;
  logic             snap_lo;
  logic [1:0]       snap_fmt;
  logic             snap_full;

  ssi_mclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .mclk_async (mclk),
    .mclk_s     (mclk_s),
    .mclk_rise  (mclk_rise),
    .mclk_fall  (mclk_fall)
  );

  ssi_frame_ctrl #(.POS_W(POS_W), .TMO_W(TMO_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mclk_s    (mclk_s),
    .mclk_fall (mclk_fall),
    .pos_in    (pos_in),
    .err_hi    (err_hi),
    .err_lo    (err_lo),
    .fmt       (fmt),
    .res_full  (res_full),
    .tmo_limit (tmo_limit),
    .busy      (busy),
    .start     (start),
    .tmo_hit   (tmo_hit),
    .snap_pos  (snap_pos),
    .snap_hi   (snap_hi),
    .snap_lo   (snap_lo),
    .snap_fmt  (snap_fmt),
    .snap_full (snap_full)
  );

  ssi_bit_seq #(.POS_W(POS_W), .LO_RES(LO_RES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .start     (start),
    .tmo_hit   (tmo_hit),
    .mclk_rise (mclk_rise),
    .snap_pos  (snap_pos),
    .snap_hi   (snap_hi),
    .snap_lo   (snap_lo),
    .snap_fmt  (snap_fmt),
    .snap_full (snap_full),
    .sdo       (sdo)
  );

endmodule

// File: tb/ssi_pos_ser_bench.sv
module ssi_pos_ser_bench;

  localparam int HALF = 8;
  localparam int TMO  = 40;
  localparam int NVEC = 10;

  // {fmt[1:0], res_full, err_hi, err_lo, pos[12:0], nclk[5:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b1, 1'b1, 13'h1A5B, 6'd16},
    {2'd0, 1'b0, 1'b0, 1'b1, 13'h12D4, 6'd12},
    {2'd1, 1'b1, 1'b1, 1'b0, 13'h0F0F, 6'd20},
    {2'd1, 1'b0, 1'b0, 1'b1, 13'h1555, 6'd16},
    {2'd2, 1'b1, 1'b1, 1'b1, 13'h1C03, 6'd30},
    {2'd2, 1'b0, 1'b0, 1'b0, 13'h0A6D, 6'd25},
    {2'd3, 1'b1, 1'b1, 1'b0, 13'h1FFF, 6'd40},
    {2'd3, 1'b0, 1'b0, 1'b1, 13'h0333, 6'd32},
    {2'd0, 1'b1, 1'b0, 1'b0, 13'h0001, 6'd14},
    {2'd1, 1'b1, 1'b0, 1'b1, 13'h1000, 6'd18}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mclk = 1'b1;
  logic [12:0] pos_in = '0;
  logic        err_hi = 1'b0;
  logic        err_lo = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        res_full = 1'b1;
  logic [15:0] tmo_limit = 16'(TMO);
  logic        sdo;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssi_pos_ser u_ssi_pos_ser (
    .clk       (clk),
    .rst       (rst),
    .mclk      (mclk),
    .pos_in    (pos_in),
    .err_hi    (err_hi),
    .err_lo    (err_lo),
    .fmt       (fmt),
    .res_full  (res_full),
    .tmo_limit (tmo_limit),
    .sdo       (sdo)
  );

  function automatic logic exp_bit(logic [1:0] f, logic r, logic [12:0] p,
                                   logic h, logic l, int k);
    int dl = r ? 13 : 10;
    int pl = dl + (f[0] ? 3 : 0);
    int kk = f[1] ? (k % (pl + 1)) : k;
    if (kk < dl) return p[dl-1-kk];
    if (f[0] && kk == dl) return h;
    if (f[0] && kk == dl + 1) return l;
    return 1'b0;
  endfunction

  function automatic string req_of(logic [1:0] f, logic r, int k);
    int dl = r ? 13 : 10;
    int pl = dl + (f[0] ? 3 : 0);
    if (f[1] && k >= pl) return "R7";
    if (k >= pl) return "R6";
    if (k >= dl) return "R5";
    return "R4";
  endfunction

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sdo=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame of n rising edges. When chg_at >= 0 all inputs are inverted
  // after that bit; expected values keep using the original capture.
  task automatic run_frame(logic [1:0] f, logic r, logic [12:0] p, logic h,
                           logic l, int n, int chg_at, bit end_tmo);
    @(negedge clk);
    fmt = f; res_full = r; pos_in = p; err_hi = h; err_lo = l;
    wait_clks(2);
    for (int k = 0; k < n; k++) begin
      mclk = 1'b0;
      wait_clks(HALF);
      if (k == 0) check("R3", sdo, 1'b1);
      mclk = 1'b1;
      wait_clks(HALF);
      check(req_of(f, r, k), sdo, exp_bit(f, r, p, h, l, k));
      if (k == chg_at) begin
        pos_in = ~p; err_hi = ~h; err_lo = ~l; fmt = ~f; res_full = ~r;
        if (k + 1 < n) check("R2", sdo, exp_bit(f, r, p, h, l, k));
      end
    end
    if (end_tmo) begin
      wait_clks(TMO + 8);
      check("R8", sdo, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clks(4);
    rst = 1'b0;
    wait_clks(2);
    check("R1", sdo, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i][23:22], VEC[i][21], VEC[i][18:6], VEC[i][20],
                VEC[i][19], int'(VEC[i][5:0]), -1, 1'b1);
    end

    // R2: inputs inverted mid-frame, in plain and ring formats.
    run_frame(2'd1, 1'b1, 13'h1234, 1'b1, 1'b0, 20, 3, 1'b1);
    run_frame(2'd3, 1'b0, 13'h02C7, 1'b0, 1'b1, 34, 5, 1'b1);

    // R8: a frame cut short by timeout, then a fresh frame from the MSB.
    run_frame(2'd0, 1'b1, 13'h1F00, 1'b0, 1'b0, 2, -1, 1'b1);
    run_frame(2'd2, 1'b1, 13'h00FF, 1'b0, 1'b0, 16, -1, 1'b1);

    // R8: a high phase shorter than the limit does not end the frame.
    tmo_limit = 16'(HALF + 6);
    run_frame(2'd1, 1'b0, 13'h0155, 1'b1, 1'b1, 14, -1, 1'b0);
    wait_clks(20);
    check("R8", sdo, 1'b1);
    tmo_limit = 16'(TMO);

    // R1: reset mid-frame returns the line high.
    run_frame(2'd0, 1'b1, 13'h0000, 1'b0, 1'b0, 3, -1, 1'b0);
    rst = 1'b1;
    wait_clks(2);
    rst = 1'b0;
    wait_clks(1);
    check("R1", sdo, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule